// File: doc/BRIEF.md
# Queue Event State Page Controller

This block holds two bits of event state, a pending bit P and a queued bit Q, for each side of each event queue. One side gates notifications, the other gates escalations. Software and hardware manage these bits through memory-mapped pages. Every queue owns two adjacent pages. The lower (even) page acts on the notification state and the upper (odd) page acts on the escalation state. The operation is chosen by the offset within the page, so a single 64-bit load or store does the whole operation in one step: raise an event, end an interrupt, read the state or force it to a value.

When a trigger or end-of-interrupt finds the state machine in a position that lets an event through, the block emits a one-cycle notify pulse. The pulse carries the queue index and the page side. Another block does the routing that follows. Each request gets a registered response one cycle later. No request stalls, so requests may arrive on every cycle.

Top module: `evq_state_pages`

## Requirements
- R1: After reset, every P/Q pair of every queue on both pages reads 00, and rsp_valid_o and notify_o are low.
- R2: A store at page offset 0x000-0x3FF is a trigger. It sets P, and Q becomes the old P OR the old Q (00 to 10, 01 to 11, 10 to 11, 11 to 11). Only the 00 to 10 step produces a notify.
- R3: An end-of-interrupt clears P and moves the old Q into P, with Q cleared. It notifies exactly when the old Q was 1. A load at offset 0x000-0x7FF performs it and returns the notify bit in rdata bit 0. A store at offset 0x400-0x7FF also performs it.
- R4: A load at offset 0x800-0xBFF returns the state as rdata[1]=P, rdata[0]=Q, with all other bits zero. The state is left unchanged.
- R5: A load at offset 0xC00-0xFFF writes P=offset bit 9 and Q=offset bit 8, and returns the old state in rdata[1:0].
- R6: The queue index is address >> (PAGE_SHIFT+1). Address bit PAGE_SHIFT selects the notification state (0) or the escalation state (1). The two states of a queue, and the states of different queues, change independently. A notify reports the queue index and the page side.
- R7: A store at offset 0x800-0xBFF on a notification page produces a notify and leaves P/Q unchanged. The same store on an escalation page returns an error and produces no notify.
- R8: The following requests change no state and raise no notify, and rsp_err_o is set: a store at offset 0xC00-0xFFF, an access whose size code is not 3 (8 bytes), and an access whose queue index is NUM_QUEUES or more. For a load among these, rdata is all ones.
- R9: Each accepted request yields rsp_valid_o, and any notify, on the clock edge that samples it. Stores return zero data. A cycle without a request yields neither a response nor a notify.
- R10: Only address bits 11:0 select the operation. With 64 KB pages (PAGE_SHIFT=16), address bits 15:12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address within the page space |
| req_size_i | input | 2 | log2 of access bytes; only 3 is legal |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_rdata_o | output | 64 | Load result; zero for stores |
| rsp_err_o | output | 1 | Request was rejected |
| notify_o | output | 1 | One-cycle event pulse |
| notify_qidx_o | output | QIDX_W | Queue of the notify |
| notify_esc_o | output | 1 | Notify came from the escalation page |

## Verification
Every result appears one clock edge after its request: the response data, the error flag, the notify pulse and the state update. A read sent on the next cycle already sees the new state. The bench drives each request on a falling edge. It holds the request across one rising edge and samples all outputs at the following falling edge, while the next request is driven at that same moment, so back-to-back traffic is exercised. The bench observes state only through GET loads, and it makes such a load right after every operation that should leave the state unchanged.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef struct packed {
    logic p;
    logic q;
  } pq_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_INJ,
    OP_BAD
  } op_e;

  localparam logic [1:0] SIZE_8B = 2'd3;
endpackage

// File: rtl/evq_op_decode.sv
module evq_op_decode
  import evq_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 8,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned QIDX_W     = 3
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output op_e               op_o,
  output logic [QIDX_W-1:0] qidx_o,
  output logic              esc_o,
  output pq_t               setval_o
);
  localparam int unsigned HI_W = ADDR_W - PAGE_SHIFT - 1;

  logic [11:0]     off;
  logic [HI_W-1:0] hi;
  logic            in_range;

  assign off      = addr_i[11:0];
  assign hi       = addr_i[ADDR_W-1:PAGE_SHIFT+1];
  assign in_range = hi < HI_W'(NUM_QUEUES);
  assign qidx_o   = hi[QIDX_W-1:0];
  assign esc_o    = addr_i[PAGE_SHIFT];
  assign setval_o = '{p: off[9], q: off[8]};

  always_comb begin
    op_o = OP_NONE;
    if (valid_i) begin
      if (size_i != SIZE_8B || !in_range) begin
        op_o = OP_BAD;
      end else if (write_i) begin
        if      (off < 12'h400) op_o = OP_TRIG;
        else if (off < 12'h800) op_o = OP_EOI;
        else if (off < 12'hC00) op_o = esc_o ? OP_BAD : OP_INJ;
        else                    op_o = OP_BAD;
      end else begin
        if      (off < 12'h800) op_o = OP_EOI;
        else if (off < 12'hC00) op_o = OP_GET;
        else                    op_o = OP_SET;
      end
    end
  end
endmodule

// File: rtl/evq_pq_update.sv
module evq_pq_update
  import evq_pkg::*;
(
  input  op_e         op_i,
  input  logic        write_i,
  input  pq_t         cur_i,
  input  pq_t         setval_i,
  output pq_t         nxt_o,
  output logic        notify_o,
  output logic [63:0] rdata_o
);
  always_comb begin
    nxt_o    = cur_i;
    notify_o = 1'b0;
    rdata_o  = '0;
    unique case (op_i)
      OP_TRIG: begin
        nxt_o    = '{p: 1'b1, q: cur_i.p | cur_i.q};
        notify_o = !cur_i.p && !cur_i.q;
      end
      OP_EOI: begin
        nxt_o    = '{p: cur_i.q, q: 1'b0};
        notify_o = cur_i.q;
        rdata_o  = {63'd0, cur_i.q};
      end
      OP_GET:  rdata_o = {62'd0, cur_i};
      OP_SET: begin
        nxt_o   = setval_i;
        rdata_o = {62'd0, cur_i};
      end
      OP_INJ:  notify_o = 1'b1;
      OP_BAD:  rdata_o = '1;
      default: ;
    endcase
    if (write_i) rdata_o = '0;
  end
endmodule

// File: rtl/evq_pq_store.sv
module evq_pq_store
  import evq_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = 8,
  parameter int unsigned QIDX_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [QIDX_W-1:0] qidx_i,
  input  logic              esc_i,
  output pq_t               rd_pq_o,
  input  logic              we_i,
  input  pq_t               wr_pq_i
);
  localparam int unsigned CELLS = 2 * NUM_QUEUES;

  pq_t cells [CELLS];

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_queue
    for (genvar e = 0; e < 2; e++) begin : g_side
      pq_t cell_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cell_q <= '0;
        end else if (we_i && qidx_i == QIDX_W'(g) && esc_i == 1'(e)) begin
          cell_q <= wr_pq_i;
        end
      end
      assign cells[2*g+e] = cell_q;
    end
  end

  logic [QIDX_W:0] rd_idx;
  assign rd_idx  = {qidx_i, esc_i};
  assign rd_pq_o = (32'(qidx_i) < NUM_QUEUES) ? cells[rd_idx] : '0;
endmodule

// File: rtl/evq_state_pages.sv
module evq_state_pages
  import evq_pkg::*;
#(
  parameter  int unsigned NUM_QUEUES = 8,
  parameter  int unsigned PAGE_SHIFT = 12,
  parameter  int unsigned ADDR_W     = 32,
  localparam int unsigned QIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              notify_o,
  output logic [QIDX_W-1:0] notify_qidx_o,
  output logic              notify_esc_o
);
  if (!(PAGE_SHIFT == 12 || PAGE_SHIFT == 16)) begin : g_bad_shift
    $error("evq_state_pages: PAGE_SHIFT must be 12 or 16");
  end

  op_e               op;
  logic [QIDX_W-1:0] qidx;
  logic              esc;
  pq_t               setval, cur_pq, nxt_pq;
  logic              ntf;
  logic [63:0]       rdata;

  evq_op_decode #(
    .NUM_QUEUES(NUM_QUEUES), .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W(ADDR_W), .QIDX_W(QIDX_W)
  ) i_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .op_o    (op),
    .qidx_o  (qidx),
    .esc_o   (esc),
    .setval_o(setval)
  );

  evq_pq_store #(.NUM_QUEUES(NUM_QUEUES), .QIDX_W(QIDX_W)) i_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qidx_i (qidx),
    .esc_i  (esc),
    .rd_pq_o(cur_pq),
    .we_i   (op != OP_NONE && op != OP_BAD && nxt_pq != cur_pq),
    .wr_pq_i(nxt_pq)
  );

  evq_pq_update i_update (
    .op_i    (op),
    .write_i (req_write_i),
    .cur_i   (cur_pq),
    .setval_i(setval),
    .nxt_o   (nxt_pq),
    .notify_o(ntf),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_rdata_o   <= '0;
      rsp_err_o     <= 1'b0;
      notify_o      <= 1'b0;
      notify_qidx_o <= '0;
      notify_esc_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= req_valid_i ? rdata : '0;
      rsp_err_o   <= op == OP_BAD;
      notify_o    <= ntf;
      if (ntf) begin
        notify_qidx_o <= qidx;
        notify_esc_o  <= esc;
      end
    end
  end
endmodule

// File: rtl/evq_state_pages_chk.sv
module evq_state_pages_chk #(
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned ADDR_W     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic [63:0]       rsp_rdata_o,
  input logic              rsp_err_o,
  input logic              notify_o
);
  logic inj_esc;
  assign inj_esc = req_valid_i && req_write_i && req_addr_i[PAGE_SHIFT]
                   && req_addr_i[11:10] == 2'b10;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !notify_o); // R9
  AST_STORE_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_write_i |=> rsp_rdata_o == 64'd0); // R9
  AST_NOTIFY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> rsp_valid_o && !rsp_err_o); // R8
  AST_BAD_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i && req_size_i != 2'd3 |=> rsp_err_o && rsp_rdata_o == '1); // R8
  AST_INJ_ESC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_esc |=> rsp_err_o && !notify_o); // R7
endmodule

bind evq_state_pages evq_state_pages_chk #(.PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_write_i(req_write_i),
  .req_addr_i(req_addr_i), .req_size_i(req_size_i), .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o), .notify_o(notify_o)
);

// File: tb/test_evq_state_pages.sv
module test_evq_state_pages;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NQ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd3;
  logic        rsp_valid, rsp_err, ntf, ntf_esc;
  logic [63:0] rsp_rdata;
  logic [2:0]  ntf_q;

  logic        w_valid = 1'b0, w_write = 1'b0;
  logic [31:0] w_addr = '0;
  logic        w_rsp_valid, w_err, w_ntf, w_esc;
  logic [63:0] w_rdata;
  logic [2:0]  w_q;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_state_pages #(.NUM_QUEUES(NQ), .PAGE_SHIFT(12), .ADDR_W(32)) i_evq_state_pages (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .notify_o(ntf),
    .notify_qidx_o(ntf_q), .notify_esc_o(ntf_esc)
  );

  evq_state_pages #(.NUM_QUEUES(NQ), .PAGE_SHIFT(16), .ADDR_W(32)) i_evq_state_pages_wide (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(w_valid), .req_write_i(w_write),
    .req_addr_i(w_addr), .req_size_i(2'd3), .rsp_valid_o(w_rsp_valid),
    .rsp_rdata_o(w_rdata), .rsp_err_o(w_err), .notify_o(w_ntf),
    .notify_qidx_o(w_q), .notify_esc_o(w_esc)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [63:0] rdata;
    logic        ntf;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam int NV = 25;
  // queue 2: notification page at 0x4000, escalation page at 0x5000
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h4800, 64'd0, 1'b0, 1'b0, 4'd4},  // R4 get after reset
    '{1'b1, 32'h4000, 64'd0, 1'b1, 1'b0, 4'd2},  // R2 00->10 notify
    '{1'b1, 32'h4010, 64'd0, 1'b0, 1'b0, 4'd2},  // R2 10->11
    '{1'b0, 32'h4800, 64'd3, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 32'h4000, 64'd1, 1'b1, 1'b0, 4'd3},  // R3 load eoi 11->10
    '{1'b0, 32'h4A00, 64'd2, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 32'h4400, 64'd0, 1'b0, 1'b0, 4'd3},  // R3 store eoi 10->00
    '{1'b0, 32'h4800, 64'd0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 32'h4D00, 64'd0, 1'b0, 1'b0, 4'd5},  // R5 set 01
    '{1'b1, 32'h4000, 64'd0, 1'b0, 1'b0, 4'd2},  // R2 01->11 quiet
    '{1'b0, 32'h4C00, 64'd3, 1'b0, 1'b0, 4'd5},  // R5 set 00
    '{1'b0, 32'h4E00, 64'd0, 1'b0, 1'b0, 4'd5},  // R5 set 10
    '{1'b0, 32'h4F00, 64'd2, 1'b0, 1'b0, 4'd5},  // R5 set 11
    '{1'b0, 32'h4800, 64'd3, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 32'h5800, 64'd0, 1'b0, 1'b0, 4'd6},  // R6 escalation untouched
    '{1'b1, 32'h5000, 64'd0, 1'b1, 1'b0, 4'd6},  // R6 escalation trigger
    '{1'b0, 32'h5800, 64'd2, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b0, 32'h4800, 64'd3, 1'b0, 1'b0, 4'd6},  // R6 notification untouched
    '{1'b1, 32'h4800, 64'd0, 1'b1, 1'b0, 4'd7},  // R7 inject
    '{1'b0, 32'h4800, 64'd3, 1'b0, 1'b0, 4'd7},  // R7 state kept
    '{1'b1, 32'h5900, 64'd0, 1'b0, 1'b1, 4'd7},  // R7 inject on escalation
    '{1'b0, 32'h5800, 64'd2, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b1, 32'h4C00, 64'd0, 1'b0, 1'b1, 4'd8},  // R8 unknown store
    '{1'b0, 32'h4800, 64'd3, 1'b0, 1'b0, 4'd8},  // R8 state kept
    '{1'b0, 32'h10800, ONES, 1'b0, 1'b1, 4'd8}   // R8 queue out of range
  };

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [31:0] addr, input logic [1:0] sz);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_size  = sz;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs idle in reset
    chk(!rsp_valid && !ntf, 1, "outputs during reset", {62'd0, rsp_valid, ntf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !ntf, 1, "outputs after reset", {62'd0, rsp_valid, ntf}, 64'd0);

    // R1 every state reads 00
    for (int q = 0; q < NQ; q++) begin
      for (int e = 0; e < 2; e++) begin
        issue(1'b0, (32'(q) << 13) | (32'(e) << 12) | 32'h800, 2'd3);
        chk(rsp_valid && rsp_rdata == 0, 1, "reset state", rsp_rdata, 64'd0);
      end
    end

    // table, back to back
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].addr, 2'd3);
      chk(rsp_valid, 9, "rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk(rsp_rdata == VECS[i].rdata, int'(VECS[i].req), "rdata", rsp_rdata, VECS[i].rdata);
      chk(ntf == VECS[i].ntf, int'(VECS[i].req), "notify", {63'd0, ntf}, {63'd0, VECS[i].ntf});
      chk(rsp_err == VECS[i].err, int'(VECS[i].req), "err", {63'd0, rsp_err}, {63'd0, VECS[i].err});
      if (VECS[i].ntf) begin
        // R6 notify identifies queue and side from the address
        chk(ntf_q == VECS[i].addr[15:13] && ntf_esc == VECS[i].addr[12], 6, "notify target",
            {60'd0, ntf_esc, ntf_q}, {60'd0, VECS[i].addr[12], VECS[i].addr[15:13]});
      end
    end

    // R8 wrong size: error, ones, no effect
    issue(1'b0, 32'h4800, 2'd2);
    chk(rsp_err && rsp_rdata == ONES, 8, "bad size load", rsp_rdata, ONES);
    issue(1'b1, 32'h6000, 2'd1);
    chk(rsp_err && !ntf, 8, "bad size trigger", {62'd0, rsp_err, ntf}, 64'd2);
    issue(1'b0, 32'h6800, 2'd3);
    chk(rsp_rdata == 0, 8, "bad size left state", rsp_rdata, 64'd0);

    // R6 highest queue, separate from queue 2
    issue(1'b1, 32'hE000, 2'd3);
    chk(ntf && ntf_q == 3'd7 && !ntf_esc, 6, "queue 7 trigger", {60'd0, ntf_esc, ntf_q}, 64'd7);

    // R9 idle cycle yields nothing
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid && !ntf, 9, "idle cycle", {62'd0, rsp_valid, ntf}, 64'd0);

    // R10 64 KB pages: bits 15:12 ignored, queue = addr >> 17
    w_valid = 1'b1; w_write = 1'b1; w_addr = 32'h0003_3000;
    @(posedge clk); @(negedge clk);
    chk(w_ntf && w_q == 3'd1 && w_esc, 10, "wide trigger", {60'd0, w_esc, w_q}, 64'd9);
    w_write = 1'b0; w_addr = 32'h0003_5800;
    @(posedge clk); @(negedge clk);
    chk(w_rdata == 64'd2 && !w_err, 10, "wide get", w_rdata, 64'd2);
    w_addr = 32'h0002_F800;
    @(posedge clk); @(negedge clk);
    chk(w_rdata == 64'd0 && w_rsp_valid, 10, "wide notification side", w_rdata, 64'd0);
    w_valid = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule